// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Port

This block is the serial edge of a stereo audio path. On every frame it shifts one left/right pair of record samples out on a serial data line and collects one left/right pair of playback samples from a serial data line. It sits in the system clock domain. It follows a bit clock and a frame clock, and both pass through a synchronizer before any edge is detected. In master mode those two clocks come from an on-chip clock divider and are also forwarded to the pins. In slave mode they are taken from the pins.

The block has four framing variants: right-aligned, left-aligned, the inter-IC sound layout, and a pulse-framed layout for signal processors. It has four word lengths. It can invert the bit clock, invert the sense of the frame clock, and exchange the two playback channels. Record samples are loaded through a strobe into 32-bit holding registers, and the top bits of each are sent. Playback samples come out left-aligned in 32-bit registers, together with a pair of valid strobes.

Top module: `audsp_port`

## Requirements
- R1: While reset is low, and in the first cycle after it, the record line, both playback valid strobes, both playback words and the pin-drive enable are all 0.
- R2: With format 01 (left-aligned), the MSB sits in the first bit slot after a frame-clock change. The left word is carried while the frame clock is high, when the polarity bit is 0.
- R3: With format 10 (inter-IC sound), the MSB sits in the second bit slot after a frame-clock change. The left word is carried while the frame clock is low, when the polarity bit is 0.
- R4: With format 00 (right-aligned), the LSB sits in the last slot of each half-frame. The half length is taken from the half-frame that came before.
- R5: With format 11 (pulse-framed), a frame starts at the bit-clock rise where a high frame clock is first seen. When the polarity bit is 0, the left MSB is in the next slot. When it is 1, the left MSB is in that same slot. The right word follows the left LSB with no gap.
- R6: Word length code 00/01/10/11 selects 16/20/24/32 bits, sent MSB first. Received words are left-aligned and the bits below them are 0. A record word is made of the top bits of its 32-bit sample.
- R7: In formats 00, 01 and 10, setting the polarity bit swaps which frame-clock level carries the left word.
- R8: The swap bit exchanges the two playback words. The record channels are not affected.
- R9: Setting the bit-clock invert bit makes the block treat falling pin edges as rising edges, and the other way round.
- R10: Playback data and the frame clock are sampled on the bit-clock rise. The record line changes only after a bit-clock fall, and it is 0 in every slot that carries no word bit.
- R11: The two playback valid strobes pulse together, for one system clock, exactly once per frame, just after the last bit of the right word arrives.
- R12: With the master bit set, the divider clocks drive the port and the pin-drive enable is 1. With it clear, the pin clocks drive the port and the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_fmt | input | 2 | Framing format code |
| cfg_wl | input | 2 | Word length code |
| cfg_lr_pol | input | 1 | Frame-clock polarity / pulse-framed submode |
| cfg_bclk_inv | input | 1 | Bit-clock invert |
| cfg_swap | input | 1 | Exchange playback channels |
| cfg_master | input | 1 | 1 = use the divider clocks and drive the pins |
| ext_bclk | input | 1 | Bit clock from the pin (slave) |
| ext_lrck | input | 1 | Frame clock from the pin (slave) |
| div_bclk | input | 1 | Bit clock from the divider (master) |
| div_lrck | input | 1 | Frame clock from the divider (master) |
| sdi | input | 1 | Serial playback data |
| sdo | output | 1 | Serial record data |
| bclk_o | output | 1 | Bit clock forwarded to the pin |
| lrck_o | output | 1 | Frame clock forwarded to the pin |
| drive_en | output | 1 | Pin drive enable for the clock outputs |
| rec_left | input | 32 | Left record sample |
| rec_right | input | 32 | Right record sample |
| rec_load | input | 1 | Load strobe for the record samples |
| pb_left | output | 32 | Left playback word, left-aligned |
| pb_right | output | 32 | Right playback word, left-aligned |
| pb_valid_l | output | 1 | Left playback valid strobe |
| pb_valid_r | output | 1 | Right playback valid strobe |

## Verification
The bench goes after slot placement at the edges of each format: the one-slot delay of the inter-IC layout, the two pulse-framed submodes, and right-aligned words whose half-frames are only one or a few slots longer than the word. A design that got any of these wrong would put every word one bit out of place, or would lose the MSB or the LSB. The bench drives random bits into the unused slots, so any leakage of them into the playback words shows up. It also checks that the record line stays 0 in those slots. Further checks cover the swap, the polarity and bit-clock inversions, and the switch to master mode. A fault in any of them would give swapped channels, mirrored words, or no frames at all.

// File: rtl/audsp_pkg.sv
// Shared types and slot decoding for the stereo serial audio port.
// Assumes slot counts and half-frame lengths fit in a signed int.
package audsp_pkg;

    typedef enum logic [1:0] {
        FMT_RALIGN = 2'b00,
        FMT_LALIGN = 2'b01,
        FMT_IIS    = 2'b10,
        FMT_PULSE  = 2'b11
    } fmt_e;

    // Where a bit slot belongs: whether it carries a word bit, which channel, and the bit index counted from the MSB
    typedef struct packed {
        logic       hit;
        logic       right;
        logic [5:0] idx;
    } slot_map_t;

    // Word length code to bit count
    function automatic int word_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 16;
            2'b01:   return 20;
            2'b10:   return 24;
            default: return 32;
        endcase
    endfunction

    // Map a slot number to a channel and bit index for the given format
    function automatic slot_map_t map_slot(input logic [1:0] fmt, input logic [1:0] wl,
                                           input logic pol, input logic lr,
                                           input int slot, input int half);
        slot_map_t m;
        int        w;
        int        p;
        logic      ok;
        m  = '0;
        w  = word_bits(wl);
        ok = 1'b1;
        case (fmt)
            FMT_PULSE: begin
                p       = slot - (pol ? 0 : 1);
                m.right = (p >= w);
                if (m.right) p = p - w;
            end
            FMT_LALIGN: begin
                p       = slot;
                m.right = ~(lr ^ pol);
            end
            FMT_IIS: begin
                p       = slot - 1;
                m.right = lr ^ pol;
            end
            default: begin
                p       = slot - (half - w);
                ok      = (half >= w);
                m.right = ~(lr ^ pol);
            end
        endcase
        if (ok && p >= 0 && p < w) begin
            m.hit = 1'b1;
            m.idx = 6'(p);
        end
        return m;
    endfunction

endpackage

// File: rtl/audsp_front.sv
// Clock front end: picks the divider or the pin clocks, synchronizes the clocks and the
// data into clk, applies the bit-clock invert and detects edges.
// Assumes the bit clock half period is several system clocks long.
module audsp_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_div,
    input  logic inv,
    input  logic ext_bclk,
    input  logic ext_lrck,
    input  logic div_bclk,
    input  logic div_lrck,
    input  logic sdi,
    output logic lr_s,
    output logic sd_s,
    output logic rise,
    output logic fall
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [2:0] raw;
    logic [2:0] chain [SYNC_STAGES];
    logic       bc;
    logic       bc_q;

    // Source select between the divider and the pins
    assign raw = sel_div ? {div_bclk, div_lrck, sdi} : {ext_bclk, ext_lrck, sdi};

    // Synchronizer chain shared by bit clock, frame clock and data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= raw;
            for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign bc = chain[LAST][2] ^ inv;

    // Previous bit-clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) bc_q <= 1'b0;
        else        bc_q <= bc;
    end

    assign rise = bc & ~bc_q;
    assign fall = ~bc & bc_q;
    assign lr_s = chain[LAST][1];
    assign sd_s = chain[LAST][0];
endmodule

// File: rtl/audsp_slot_track.sv
// Slot tracker: counts bit slots from the frame start and learns the half-frame length.
// slot_now names the slot of a rise happening now, or of the rise after a fall happening now.
// Assumes the frame clock changes together with a bit-clock fall.
module audsp_slot_track #(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              lr_s,
    input  logic              is_pulse,
    output logic [SLOT_W-1:0] slot_now,
    output logic [SLOT_W-1:0] half_len
);
    localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

    logic              lr_q;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] inc;
    logic              start;

    // Frame or half-frame start, and the next slot number (saturating)
    always_comb begin
        start    = is_pulse ? (lr_s & ~lr_q) : (lr_s ^ lr_q);
        inc      = (slot_q == SLOT_MAX) ? slot_q : slot_q + 1'b1;
        slot_now = start ? '0 : inc;
    end

    // Advance the slot state on every bit-clock rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_q     <= 1'b0;
            slot_q   <= SLOT_MAX;
            half_len <= '0;
        end else if (rise) begin
            lr_q   <= lr_s;
            slot_q <= slot_now;
            if (start && !is_pulse) half_len <= inc;
        end
    end
endmodule

// File: rtl/audsp_rx.sv
// Playback receiver: takes in the serial bits left-aligned and presents both words
// with valid strobes once the right word is complete. Applies the channel swap.
module audsp_rx
    import audsp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          sd,
    input  slot_map_t     hit,
    input  logic [1:0]    wl,
    input  logic          swap,
    output logic [DW-1:0] pb_left,
    output logic [DW-1:0] pb_right,
    output logic          v_l,
    output logic          v_r
);
    logic [DW-1:0] acc_l, acc_r, nl, nr;
    logic          done;
    int            pos;

    // Next accumulator contents and end-of-frame detection
    always_comb begin
        nl   = acc_l;
        nr   = acc_r;
        done = 1'b0;
        pos  = DW - 1 - int'(hit.idx);
        if (rise && hit.hit && pos >= 0) begin
            if (hit.right) begin
                if (hit.idx == '0) nr = '0;
                nr[pos] = sd;
                done    = (int'(hit.idx) == word_bits(wl) - 1);
            end else begin
                if (hit.idx == '0) nl = '0;
                nl[pos] = sd;
            end
        end
    end

    // Accumulators, output words and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_l    <= '0;
            acc_r    <= '0;
            pb_left  <= '0;
            pb_right <= '0;
            v_l      <= 1'b0;
            v_r      <= 1'b0;
        end else begin
            acc_l <= nl;
            acc_r <= nr;
            v_l   <= done;
            v_r   <= done;
            if (done) begin
                pb_left  <= swap ? nr : nl;
                pb_right <= swap ? nl : nr;
            end
        end
    end
endmodule

// File: rtl/audsp_tx.sv
// Record transmitter: holds the record samples and drives one bit per slot after each
// bit-clock fall, MSB first, with 0 in slots that carry no word bit.
module audsp_tx
    import audsp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall,
    input  slot_map_t     hit,
    input  logic [DW-1:0] rec_left,
    input  logic [DW-1:0] rec_right,
    input  logic          rec_load,
    output logic          sdo
);
    logic [DW-1:0] hold_l, hold_r, word;
    int            pos;

    // Sample holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
        end else if (rec_load) begin
            hold_l <= rec_left;
            hold_r <= rec_right;
        end
    end

    assign word = hit.right ? hold_r : hold_l;
    assign pos  = DW - 1 - int'(hit.idx);

    // Serial output update on each bit-clock fall
    always_ff @(posedge clk) begin
        if (!rst_n)    sdo <= 1'b0;
        else if (fall) sdo <= (hit.hit && pos >= 0) ? word[pos] : 1'b0;
    end
endmodule

// File: rtl/audsp_port.sv
// Top of the stereo serial audio port. It ties together the clock front end, the slot
// tracker, the receiver and the transmitter. One slot map serves both directions: the
// receiver uses it at a rise, and the transmitter uses it at the fall before that rise.
module audsp_port
    import audsp_pkg::*;
#(
    parameter int DW          = 32,
    parameter int SLOT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_fmt,
    input  logic [1:0]    cfg_wl,
    input  logic          cfg_lr_pol,
    input  logic          cfg_bclk_inv,
    input  logic          cfg_swap,
    input  logic          cfg_master,
    input  logic          ext_bclk,
    input  logic          ext_lrck,
    input  logic          div_bclk,
    input  logic          div_lrck,
    input  logic          sdi,
    output logic          sdo,
    output logic          bclk_o,
    output logic          lrck_o,
    output logic          drive_en,
    input  logic [DW-1:0] rec_left,
    input  logic [DW-1:0] rec_right,
    input  logic          rec_load,
    output logic [DW-1:0] pb_left,
    output logic [DW-1:0] pb_right,
    output logic          pb_valid_l,
    output logic          pb_valid_r
);
    logic              lr_s, sd_s, rise_w, fall_w;
    logic [SLOT_W-1:0] slot_now, half_len;
    slot_map_t         hit;

    audsp_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .sel_div(cfg_master), .inv(cfg_bclk_inv),
        .ext_bclk(ext_bclk), .ext_lrck(ext_lrck), .div_bclk(div_bclk), .div_lrck(div_lrck),
        .sdi(sdi), .lr_s(lr_s), .sd_s(sd_s), .rise(rise_w), .fall(fall_w)
    );

    audsp_slot_track #(.SLOT_W(SLOT_W)) u_track (
        .clk(clk), .rst_n(rst_n), .rise(rise_w), .lr_s(lr_s),
        .is_pulse(cfg_fmt == FMT_PULSE), .slot_now(slot_now), .half_len(half_len)
    );

    // Slot decoding shared by both directions
    assign hit = map_slot(cfg_fmt, cfg_wl, cfg_lr_pol, lr_s, int'(slot_now), int'(half_len));

    audsp_rx #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .rise(rise_w), .sd(sd_s), .hit(hit), .wl(cfg_wl),
        .swap(cfg_swap), .pb_left(pb_left), .pb_right(pb_right),
        .v_l(pb_valid_l), .v_r(pb_valid_r)
    );

    audsp_tx #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .fall(fall_w), .hit(hit), .rec_left(rec_left),
        .rec_right(rec_right), .rec_load(rec_load), .sdo(sdo)
    );

    // Forward the divider clocks to the pins
    assign bclk_o = div_bclk;
    assign lrck_o = div_lrck;

    // Pin drive enable follows the master bit
    always_ff @(posedge clk) begin
        if (!rst_n) drive_en <= 1'b0;
        else        drive_en <= cfg_master;
    end
endmodule

// File: rtl/audsp_port_chk.sv
// Property checker for the stereo serial audio port, attached to the top through bind.
module audsp_port_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fall,
    input logic          sdo,
    input logic          pb_valid_l,
    input logic          pb_valid_r,
    input logic          cfg_master,
    input logic          drive_en,
    input logic [1:0]    cfg_wl,
    input logic [DW-1:0] pb_left,
    input logic [DW-1:0] pb_right
);
    // R1: quiet outputs during reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!pb_valid_l && !pb_valid_r && !sdo && !drive_en));

    // R11: each strobe lasts one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_valid_l || pb_valid_r) |=> (!pb_valid_l && !pb_valid_r));

    // R10: the record line only moves after a bit-clock fall
    a_r10_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(sdo));

    // R6: short words are left-aligned, with zeros below
    a_r6_short_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_valid_l && cfg_wl == 2'b00) |-> (pb_left[DW-17:0] == '0 && pb_right[DW-17:0] == '0));

    // R12: the pin enable follows the master bit one cycle later
    a_r12_drive: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (drive_en == $past(cfg_master)));
endmodule

bind audsp_port audsp_port_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fall(fall_w), .sdo(sdo), .pb_valid_l(pb_valid_l),
    .pb_valid_r(pb_valid_r), .cfg_master(cfg_master), .drive_en(drive_en),
    .cfg_wl(cfg_wl), .pb_left(pb_left), .pb_right(pb_right)
);

// File: tb/audsp_port_test.sv
// Bench for the stereo serial audio port: directed corner configurations plus random ones.
// Each configuration runs three frames. The first frame fills the pipeline, and the other two are checked.
module audsp_port_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  cfg_fmt = 0, cfg_wl = 0;
    logic        cfg_lr_pol = 0, cfg_bclk_inv = 0, cfg_swap = 0, cfg_master = 0;
    logic        ext_bclk = 1, ext_lrck = 0, div_bclk = 0, div_lrck = 0, sdi = 0;
    logic        sdo, bclk_o, lrck_o, drive_en;
    logic [31:0] rec_left = 0, rec_right = 0;
    logic        rec_load = 0;
    logic [31:0] pb_left, pb_right;
    logic        pb_valid_l, pb_valid_r;

    int n_checks = 0, n_errors = 0;
    int vcnt = 0, pair_err = 0;
    logic [31:0] cap_l, cap_r;
    int cycles = 0;

    audsp_port uut (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_wl(cfg_wl), .cfg_lr_pol(cfg_lr_pol),
        .cfg_bclk_inv(cfg_bclk_inv), .cfg_swap(cfg_swap), .cfg_master(cfg_master),
        .ext_bclk(ext_bclk), .ext_lrck(ext_lrck), .div_bclk(div_bclk), .div_lrck(div_lrck),
        .sdi(sdi), .sdo(sdo), .bclk_o(bclk_o), .lrck_o(lrck_o), .drive_en(drive_en),
        .rec_left(rec_left), .rec_right(rec_right), .rec_load(rec_load),
        .pb_left(pb_left), .pb_right(pb_right), .pb_valid_l(pb_valid_l), .pb_valid_r(pb_valid_r)
    );

    always #5 clk = ~clk;

    // Capture the playback strobes
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (pb_valid_l) begin
            vcnt  <= vcnt + 1;
            cap_l <= pb_left;
            cap_r <= pb_right;
        end
        if (pb_valid_l !== pb_valid_r) pair_err <= pair_err + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int wbits(input int code);
        return (code == 0) ? 16 : (code == 1) ? 20 : (code == 2) ? 24 : 32;
    endfunction

    // Expected bit index for a slot, from the format rules; -1 = unused slot
    function automatic int exp_k(input int fmt, input int w, input int pol, input int s,
                                 input int h, input int hl, output bit rt);
        int p;
        rt = (h == 1);
        case (fmt)
            1: return (s < w) ? s : -1;
            2: return (s >= 1 && s <= w) ? s - 1 : -1;
            0: return (s >= hl - w) ? s - (hl - w) : -1;
            default: begin
                p = s - (pol ? 0 : 1);
                if (p >= 0 && p < w) begin rt = 0; return p; end
                if (p >= w && p < 2 * w) begin rt = 1; return p - w; end
                return -1;
            end
        endcase
    endfunction

    // Drive the selected clock source with a logical bit-clock level
    task automatic put_pins(input logic b, input logic lr);
        if (cfg_master) begin
            div_bclk = b ^ cfg_bclk_inv; div_lrck = lr; ext_bclk = 0; ext_lrck = 0;
        end else begin
            ext_bclk = b ^ cfg_bclk_inv; ext_lrck = lr; div_bclk = 0; div_lrck = 0;
        end
    endtask

    // One bit slot: fall with new frame clock and data, sample record, then rise
    task automatic one_slot(input logic lr, input logic d, output logic got);
        @(negedge clk);
        put_pins(1'b0, lr);
        sdi = d;
        repeat (5) @(negedge clk);
        got = sdo;
        put_pins(1'b1, lr);
        repeat (6) @(negedge clk);
    endtask

    function automatic string tag(input int fmt);
        string t;
        t = (fmt == 0) ? "R4" : (fmt == 1) ? "R2" : (fmt == 2) ? "R3" : "R5";
        if (cfg_lr_pol && fmt != 3) t = {t, "/R7"};
        if (cfg_bclk_inv) t = {t, "/R9"};
        if (cfg_master) t = {t, "/R12"};
        return t;
    endfunction

    task automatic run_frame(input int hl, input bit chk);
        logic [31:0] sl, sr, mask;
        int fmt, w, pol, v0, nslot, bad_s, k;
        logic got, e, lr, d, badg, bade;
        bit rt;
        fmt = int'(cfg_fmt); w = wbits(int'(cfg_wl)); pol = int'(cfg_lr_pol);
        sl = $urandom; sr = $urandom;
        v0 = vcnt; bad_s = -1; badg = 0; bade = 0;
        nslot = (fmt == 3) ? hl : 2 * hl;
        for (int i = 0; i < nslot; i++) begin
            int h, s;
            h = (fmt == 3) ? 0 : i / hl;
            s = (fmt == 3) ? i : i % hl;
            k = exp_k(fmt, w, pol, s, h, hl, rt);
            if (fmt == 3) lr = (s == 0);
            else lr = ((fmt == 2) ? cfg_lr_pol : ~cfg_lr_pol) ^ (h == 1);
            d = (k >= 0) ? (rt ? sr[31-k] : sl[31-k]) : 1'($urandom);
            e = (k >= 0) ? (rt ? rec_right[31-k] : rec_left[31-k]) : 1'b0;
            one_slot(lr, d, got);
            if (got !== e && bad_s < 0) begin bad_s = i; badg = got; bade = e; end
        end
        if (chk) begin
            // R10 unused record slots read 0; R6 top bits of the record sample are sent
            check(bad_s < 0, {tag(fmt), "/R6/R10"}, $sformatf("record bit slot %0d", bad_s),
                  longint'(badg), longint'(bade));
            check(vcnt - v0 == 1, "R11", "valid pulses per frame", vcnt - v0, 1);
            mask = 32'hFFFF_FFFF << (32 - w);
            check(cap_l === ((cfg_swap ? sr : sl) & mask), {tag(fmt), cfg_swap ? "/R8" : "/R6"},
                  "playback left", longint'(cap_l), longint'((cfg_swap ? sr : sl) & mask));
            check(cap_r === ((cfg_swap ? sl : sr) & mask), {tag(fmt), cfg_swap ? "/R8" : "/R6"},
                  "playback right", longint'(cap_r), longint'((cfg_swap ? sl : sr) & mask));
        end
    endtask

    task automatic run_cfg(input int fmt, input int wl, input int pol, input int inv,
                           input int swp, input int ms, input int extra);
        logic got;
        int w, hl;
        logic idle_lr;
        w = wbits(wl);
        @(negedge clk);
        cfg_fmt = 2'(fmt); cfg_wl = 2'(wl); cfg_lr_pol = 1'(pol);
        cfg_bclk_inv = 1'(inv); cfg_swap = 1'(swp); cfg_master = 1'(ms);
        idle_lr = (fmt == 3) ? 1'b0 : ~(((fmt == 2) ? cfg_lr_pol : ~cfg_lr_pol));
        put_pins(1'b1, idle_lr);
        rec_left = $urandom; rec_right = $urandom; rec_load = 1;
        @(negedge clk); rec_load = 0;
        repeat (10) @(negedge clk);
        // R12 master selection drives the pin enable and forwards the divider clocks
        check(drive_en === cfg_master && bclk_o === div_bclk && lrck_o === div_lrck, "R12",
              "pin drive enable", longint'(drive_en), longint'(cfg_master));
        for (int i = 0; i < 3; i++) one_slot(idle_lr, 1'b0, got);
        hl = (fmt == 3) ? 2 * w + 1 + extra : w + 1 + extra;
        for (int f = 0; f < 3; f++) run_frame(hl, f > 0);
    endtask

    // Watchdog
    initial begin
        wait (cycles >= 190000);
        n_errors++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, 190000);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R1 reset state
        check(sdo === 0 && pb_valid_l === 0 && pb_valid_r === 0 && pb_left === 0 &&
              drive_en === 0, "R1", "reset outputs", longint'({sdo, pb_valid_l, drive_en}), 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // Directed corner configurations: fmt, wl, pol, inv, swap, master, extra slots
        run_cfg(0, 0, 0, 0, 0, 0, 0);   // R4 half-frame is one slot longer than the word
        run_cfg(0, 3, 0, 0, 0, 0, 4);   // R4 32-bit word
        run_cfg(1, 2, 0, 0, 0, 0, 2);   // R2
        run_cfg(2, 3, 0, 0, 0, 0, 0);   // R3 LSB in the last slot of the half
        run_cfg(3, 1, 0, 0, 0, 0, 0);   // R5 submode with a one-slot delay
        run_cfg(3, 0, 1, 0, 0, 0, 3);   // R5 submode with no delay
        run_cfg(1, 0, 1, 0, 1, 0, 1);   // R7 R8
        run_cfg(2, 1, 1, 1, 0, 0, 2);   // R7 R9
        run_cfg(0, 2, 1, 1, 0, 1, 1);   // R9 R12
        run_cfg(3, 3, 1, 0, 1, 1, 0);   // R8 R12
        for (int n = 0; n < 14; n++)
            run_cfg($urandom % 4, $urandom % 4, $urandom % 2, $urandom % 2,
                    $urandom % 2, $urandom % 2, $urandom % 4);
        // R11 both strobes always move together
        check(pair_err == 0, "R11", "strobe pairing mismatches", pair_err, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule